// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Timer

This block owns the clock-enable level of a DDR2 memory device and counts out the waits that surround low-power states. A power manager sends single-cycle requests to put the device into precharge power-down, active power-down or self refresh, and a request to wake it again. The block decides when the clock-enable pin may actually move. After a wake it reports, on two separate flags, when the command arbiter may again issue a read and when it may issue any other command.

The wait before a read depends on the state being left. After active power-down it also depends on the slow-exit mode bit and the additive latency. Entry into a low state is held back until on-die termination has been quiet for long enough, and also until termination timing has re-settled after the previous wake. Requests that arrive while such a wait is running are remembered and served later. A third flag tells the clock generator when the operating frequency may be changed.

Top module: `pdx_cke_timer`

## Requirements
- R1: Out of reset the clock enable is high, both command-allowed flags are high and the frequency-change flag is low.
- R2: In the active state, an entry request whose conditions are met drives clock enable low at the next clock edge, and both command flags fall on that same edge. When several requests are present at once, self refresh wins over precharge power-down, which wins over active power-down.
- R3: Once clock enable changes level, it keeps the new level for at least 3 rising edges. A wake request that arrives sooner is held and served on the first edge allowed.
- R4: Entry takes place only after the ODT-activity input has been sampled low on 3 consecutive edges. An entry request made while ODT is active is held, not lost.
- R5: On leaving precharge power-down, the read flag and the non-read flag each rise 2 cycles after clock enable rises.
- R6: On leaving active power-down with the slow-exit bit at 0, both flags rise 2 cycles after clock enable rises, whatever the additive latency.
- R7: On leaving active power-down with the slow-exit bit at 1, the read flag rises max(7 - AL, 1) cycles after clock enable rises, where AL is the 3-bit additive-latency input. The non-read flag rises after 2 cycles.
- R8: On leaving self refresh, the read flag rises 200 cycles after clock enable rises and the non-read flag rises after 28 cycles.
- R9: The frequency-change flag is high exactly while the device sits in self refresh or precharge power-down. It is low in active power-down and from the edge on which clock enable rises.
- R10: A new entry waits until both command flags are high and 8 cycles have passed since clock enable rose. An entry request made during that time is held and served afterwards.
- R11: A wake request in the active state has no effect. An entry request made while the device is in a low state has no effect and is not kept for later.
- R12: The slow-exit bit and the additive latency do not change the exit waits of precharge power-down or self refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_pre_req_i | input | 1 | Pulse: request precharge power-down |
| pd_act_req_i | input | 1 | Pulse: request active power-down |
| sref_req_i | input | 1 | Pulse: request self refresh |
| wake_req_i | input | 1 | Pulse: request return to the active state |
| slow_exit_i | input | 1 | Mode bit: 1 selects slow active power-down exit |
| add_lat_i | input | AL_W (3) | Programmed additive latency in cycles |
| odt_busy_i | input | 1 | High while on-die termination is active or changing |
| cke_o | output | 1 | Clock-enable level to the device |
| rd_ok_o | output | 1 | A read command may be issued |
| nrd_ok_o | output | 1 | A command other than a read may be issued |
| fchg_ok_o | output | 1 | The clock frequency may be changed |

## Verification
The bench goes after the boundaries of the exit waits. It covers the slow active exit over several latencies, including the clamp at one cycle for AL of 7. A design that subtracted without clamping would wrap to a very long wait or open the read gate at once. The bench also sends a wake right after entry, to check the three-edge hold. A design that ignored the hold would raise clock enable after one cycle, and one that dropped the early wake would stay asleep.

Requests are also placed inside the ODT-settle and post-exit termination windows. A design that acted on them at once would lower clock enable early, and one that discarded them would never enter. Further tests check the entry priority, and check that a stray wake in the active state or a stray entry in a low state is discarded. Keeping either request would cause a spurious wake or an unwanted re-entry later.

// File: rtl/pdx_pkg.sv
`timescale 1ns/1ps
package pdx_pkg;

  // Power state of the attached device as tracked by the timer
  typedef enum logic [2:0] {
    ST_ACTIVE   = 3'd0,
    ST_PRE_PD   = 3'd1,
    ST_ACT_PD   = 3'd2,
    ST_SELF_REF = 3'd3,
    ST_EXITING  = 3'd4
  } pdx_state_e;

  // Bit positions inside the pending-entry vector
  localparam int unsigned ENT_ACT = 0;
  localparam int unsigned ENT_PRE = 1;
  localparam int unsigned ENT_SR  = 2;
  localparam int unsigned ENT_W   = 3;

  function automatic logic pdx_is_low(input pdx_state_e s);
    return (s == ST_PRE_PD) || (s == ST_ACT_PD) || (s == ST_SELF_REF);
  endfunction

  function automatic logic pdx_freq_safe(input pdx_state_e s);
    return (s == ST_PRE_PD) || (s == ST_SELF_REF);
  endfunction

endpackage

// File: rtl/pdx_level_hold.sv
`timescale 1ns/1ps
// Counts rising edges since the guarded level last changed.
module pdx_level_hold #(
  parameter int unsigned HOLD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic toggle_i,
  input  logic level_i,
  output logic hold_done_o
);
  localparam int unsigned HW = (HOLD > 1) ? $clog2(HOLD + 1) : 1;
  localparam logic [HW-1:0] LAST = HW'(HOLD - 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= LAST;
    else if (toggle_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign hold_done_o = (cnt_q == LAST);

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !hold_done_o |=> $stable(level_i)) else $error("level moved inside hold window"); // R3
  AST_TOGGLE_GATED: assert property (@(posedge clk) disable iff (rst)
    toggle_i |-> hold_done_o) else $error("toggle requested before hold done"); // R3

endmodule

// File: rtl/pdx_odt_quiet.sv
`timescale 1ns/1ps
// Reports that the ODT activity input has stayed low for SETTLE edges.
module pdx_odt_quiet #(
  parameter int unsigned SETTLE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  output logic quiet_o
);
  localparam int unsigned QW = $clog2(SETTLE + 1);
  localparam logic [QW-1:0] FULL = QW'(SETTLE);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (busy_i)        cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign quiet_o = (cnt_q == FULL);

  AST_BUSY_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !quiet_o) else $error("quiet reported right after ODT activity"); // R4

endmodule

// File: rtl/pdx_gate_countdown.sv
`timescale 1ns/1ps
// Down-counter that opens a gate when it reaches its end.
module pdx_gate_countdown #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          ok_o
);
  logic [CW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ok_q  <= 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      ok_q  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      ok_q  <= (cnt_q == CW'(1));
    end
  end

  assign ok_o = ok_q;

  AST_GATE_SHUT_COUNTING: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> !ok_q) else $error("gate open while counting"); // R8
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load_i |-> (load_val_i != '0)) else $error("zero wait loaded"); // R7

endmodule

// File: rtl/pdx_cke_timer.sv
`timescale 1ns/1ps
module pdx_cke_timer
  import pdx_pkg::*;
#(
  parameter int unsigned CKE_HOLD       = 3,
  parameter int unsigned ODT_SETTLE     = 3,
  parameter int unsigned ODT_EXIT       = 8,
  parameter int unsigned XP_CLK         = 2,
  parameter int unsigned XARD_FAST      = 2,
  parameter int unsigned XARD_SLOW_BASE = 7,
  parameter int unsigned XSRD_CLK       = 200,
  parameter int unsigned XSNR_CLK       = 28,
  parameter int unsigned AL_W           = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pd_pre_req_i,
  input  logic            pd_act_req_i,
  input  logic            sref_req_i,
  input  logic            wake_req_i,
  input  logic            slow_exit_i,
  input  logic [AL_W-1:0] add_lat_i,
  input  logic            odt_busy_i,
  output logic            cke_o,
  output logic            rd_ok_o,
  output logic            nrd_ok_o,
  output logic            fchg_ok_o
);
  localparam int unsigned MAX_SR  = (XSRD_CLK > XSNR_CLK) ? XSRD_CLK : XSNR_CLK;
  localparam int unsigned MAX_PD  = (XARD_SLOW_BASE > XARD_FAST) ? XARD_SLOW_BASE : XARD_FAST;
  localparam int unsigned MAX_AUX = (ODT_EXIT > XP_CLK) ? ODT_EXIT : XP_CLK;
  localparam int unsigned MAX_A   = (MAX_SR > MAX_PD) ? MAX_SR : MAX_PD;
  localparam int unsigned DLY_MAX = (MAX_A > MAX_AUX) ? MAX_A : MAX_AUX;
  localparam int unsigned CW      = $clog2(DLY_MAX + 1);

  localparam int unsigned NGATE    = 3;
  localparam int unsigned GATE_RD  = 0;
  localparam int unsigned GATE_NRD = 1;
  localparam int unsigned GATE_ODT = 2;

  pdx_state_e       state_q, state_d;
  logic             cke_q, cke_d;
  logic             fchg_q;
  logic [ENT_W-1:0] pend_q, pend_d, want;
  logic             wake_pend_q, wake_pend_d;
  logic             want_wake, in_low, entry_go, wake_go, toggle;
  logic             hold_done, odt_quiet;
  logic [CW-1:0]    slow_rd;
  logic [CW-1:0]    gate_val [NGATE];
  logic [NGATE-1:0] gate_clr;
  logic [NGATE-1:0] gate_ok;

  // Slow active exit read wait: base minus AL, never below one cycle
  always_comb begin
    if (32'(add_lat_i) + 32'd1 >= XARD_SLOW_BASE) slow_rd = CW'(1);
    else slow_rd = CW'(XARD_SLOW_BASE - 32'(add_lat_i));
  end

  // Exit waits selected by the state being left
  always_comb begin
    gate_val[GATE_RD]  = CW'(XP_CLK);
    gate_val[GATE_NRD] = CW'(XP_CLK);
    gate_val[GATE_ODT] = CW'(ODT_EXIT);
    case (state_q)
      ST_ACT_PD: gate_val[GATE_RD] = slow_exit_i ? slow_rd : CW'(XARD_FAST);
      ST_SELF_REF: begin
        gate_val[GATE_RD]  = CW'(XSRD_CLK);
        gate_val[GATE_NRD] = CW'(XSNR_CLK);
      end
      default: ;
    endcase
  end

  // State transitions
  always_comb begin
    want      = pend_q | {sref_req_i, pd_pre_req_i, pd_act_req_i};
    want_wake = wake_pend_q | wake_req_i;
    in_low    = pdx_is_low(state_q);
    entry_go  = (state_q == ST_ACTIVE) && (want != '0) && hold_done &&
                odt_quiet && gate_ok[GATE_ODT];
    wake_go   = in_low && want_wake && hold_done;

    state_d = state_q;
    if (entry_go) begin
      if (want[ENT_SR])       state_d = ST_SELF_REF;
      else if (want[ENT_PRE]) state_d = ST_PRE_PD;
      else                    state_d = ST_ACT_PD;
    end else if (wake_go) begin
      state_d = ST_EXITING;
    end else if (state_q == ST_EXITING && gate_ok[GATE_RD] && gate_ok[GATE_NRD]) begin
      state_d = ST_ACTIVE;
    end

    cke_d  = entry_go ? 1'b0 : (wake_go ? 1'b1 : cke_q);
    toggle = (cke_d != cke_q);

    if (entry_go) pend_d = '0;
    else if (state_q == ST_ACTIVE || state_q == ST_EXITING) pend_d = want;
    else pend_d = '0;

    if (wake_go)     wake_pend_d = 1'b0;
    else if (in_low) wake_pend_d = want_wake;
    else             wake_pend_d = 1'b0;

    gate_clr[GATE_RD]  = entry_go;
    gate_clr[GATE_NRD] = entry_go;
    gate_clr[GATE_ODT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_ACTIVE;
      cke_q       <= 1'b1;
      fchg_q      <= 1'b0;
      pend_q      <= '0;
      wake_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cke_q       <= cke_d;
      fchg_q      <= pdx_freq_safe(state_d);
      pend_q      <= pend_d;
      wake_pend_q <= wake_pend_d;
    end
  end

  pdx_level_hold #(.HOLD(CKE_HOLD)) u_hold (
    .clk(clk), .rst(rst), .toggle_i(toggle), .level_i(cke_q), .hold_done_o(hold_done)
  );

  pdx_odt_quiet #(.SETTLE(ODT_SETTLE)) u_odt (
    .clk(clk), .rst(rst), .busy_i(odt_busy_i), .quiet_o(odt_quiet)
  );

  for (genvar g = 0; g < NGATE; g++) begin : g_gate
    pdx_gate_countdown #(.CW(CW)) u_gate (
      .clk(clk), .rst(rst), .clr_i(gate_clr[g]), .load_i(wake_go),
      .load_val_i(gate_val[g]), .ok_o(gate_ok[g])
    );
  end

  assign cke_o     = cke_q;
  assign rd_ok_o   = gate_ok[GATE_RD];
  assign nrd_ok_o  = gate_ok[GATE_NRD];
  assign fchg_ok_o = fchg_q;

  AST_ENTRY_SHUTS_CMDS: assert property (@(posedge clk) disable iff (rst)
    $fell(cke_q) |-> (!gate_ok[GATE_RD] && !gate_ok[GATE_NRD])) else $error("commands open at entry"); // R2
  AST_ENTRY_ODT_SETTLED: assert property (@(posedge clk) disable iff (rst)
    $fell(cke_q) |-> $past(odt_quiet)) else $error("entry while ODT unsettled"); // R4
  AST_ENTRY_AFTER_GUARD: assert property (@(posedge clk) disable iff (rst)
    $fell(cke_q) |-> $past(gate_ok[GATE_ODT])) else $error("entry inside ODT exit window"); // R10
  AST_NO_CMDS_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> (!gate_ok[GATE_RD] && !gate_ok[GATE_NRD])) else $error("command flag high while asleep"); // R5
  AST_FREQ_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    fchg_q |-> !cke_q) else $error("frequency change allowed while awake"); // R9
  AST_WAKE_CLOSES_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_q) |-> !gate_ok[GATE_RD]) else $error("read open on wake edge"); // R8

endmodule

// File: tb/tb_pdx_cke_timer.sv
`timescale 1ns/1ps
module tb_pdx_cke_timer;

  logic       clk = 1'b0;
  logic       rst;
  logic       pd_pre, pd_act, sref, wake, slow_exit, odt_busy;
  logic [2:0] add_lat;
  logic       cke, rd_ok, nrd_ok, fchg;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  pdx_cke_timer dut (
    .clk(clk), .rst(rst), .pd_pre_req_i(pd_pre), .pd_act_req_i(pd_act),
    .sref_req_i(sref), .wake_req_i(wake), .slow_exit_i(slow_exit),
    .add_lat_i(add_lat), .odt_busy_i(odt_busy), .cke_o(cke),
    .rd_ok_o(rd_ok), .nrd_ok_o(nrd_ok), .fchg_ok_o(fchg)
  );

  // kind: 0 precharge power-down, 1 active power-down, 2 self refresh
  typedef struct packed {
    logic [1:0] kind;
    logic       slow;
    logic [2:0] al;
    logic [7:0] rd;
    logic [7:0] nrd;
    logic       fchg;
    logic [3:0] rtag;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 3'd0, 8'd2,   8'd2,  1'b1, 4'd5},   // R5 precharge exit
    '{2'd0, 1'b1, 3'd3, 8'd2,   8'd2,  1'b1, 4'd12},  // R12 slow bit ignored
    '{2'd1, 1'b0, 3'd0, 8'd2,   8'd2,  1'b0, 4'd6},   // R6 fast active exit
    '{2'd1, 1'b0, 3'd5, 8'd2,   8'd2,  1'b0, 4'd6},   // R6 AL ignored when fast
    '{2'd1, 1'b1, 3'd0, 8'd7,   8'd2,  1'b0, 4'd7},   // R7 slow, AL 0
    '{2'd1, 1'b1, 3'd3, 8'd4,   8'd2,  1'b0, 4'd7},   // R7 slow, AL 3
    '{2'd1, 1'b1, 3'd5, 8'd2,   8'd2,  1'b0, 4'd7},   // R7 slow, AL 5
    '{2'd1, 1'b1, 3'd7, 8'd1,   8'd2,  1'b0, 4'd7},   // R7 clamp at one
    '{2'd2, 1'b0, 3'd0, 8'd200, 8'd28, 1'b1, 4'd8},   // R8 self refresh exit
    '{2'd2, 1'b1, 3'd4, 8'd200, 8'd28, 1'b1, 4'd12}   // R12 mode inputs ignored
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive_entry(input logic [1:0] kind);
    pd_pre = (kind == 2'd0);
    pd_act = (kind == 2'd1);
    sref   = (kind == 2'd2);
    tick();
    pd_pre = 1'b0; pd_act = 1'b0; sref = 1'b0;
  endtask

  task automatic wake_settle(input int n);
    wake = 1'b1;
    tick();
    wake = 1'b0;
    repeat (n) tick();
  endtask

  task automatic wake_measure(output int rd_t, output int nrd_t);
    wake = 1'b1;
    tick();
    wake = 1'b0;
    check(cke == 1'b1, "R3 clock enable up after wake", cke, 1);
    check(fchg == 1'b0, "R9 frequency flag drops on wake", fchg, 0);
    rd_t = -1;
    nrd_t = -1;
    for (int t = 1; t <= 400 && (rd_t < 0 || nrd_t < 0); t++) begin
      tick();
      if (rd_ok && rd_t < 0) rd_t = t;
      if (nrd_ok && nrd_t < 0) nrd_t = t;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int rt;
    int nt;
    repeat (12) tick();
    slow_exit = v.slow;
    add_lat   = v.al;
    drive_entry(v.kind);
    check(cke == 1'b0, "R2 clock enable low after entry", cke, 0);
    check(rd_ok == 1'b0 && nrd_ok == 1'b0, "R2 flags shut on entry", rd_ok, 0);
    check(fchg == v.fchg, "R9 frequency flag in low state", fchg, v.fchg);
    repeat (4) tick();
    wake_measure(rt, nt);
    check(rt == v.rd, $sformatf("R%0d read wait", v.rtag), rt, v.rd);
    check(nt == v.nrd, $sformatf("R%0d non-read wait", v.rtag), nt, v.nrd);
    slow_exit = 1'b0;
    add_lat   = 3'd0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int rt;
    int nt;
    int guard;
    rst = 1'b1;
    pd_pre = 1'b0; pd_act = 1'b0; sref = 1'b0; wake = 1'b0;
    slow_exit = 1'b0; odt_busy = 1'b0; add_lat = 3'd0;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check(cke == 1'b1, "R1 clock enable", cke, 1);
    check(rd_ok == 1'b1, "R1 read flag", rd_ok, 1);
    check(nrd_ok == 1'b1, "R1 non-read flag", nrd_ok, 1);
    check(fchg == 1'b0, "R1 frequency flag", fchg, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R4: entry held while ODT active, served 3 quiet edges later
    repeat (12) tick();
    odt_busy = 1'b1;
    tick();
    pd_pre = 1'b1;
    tick();
    pd_pre = 1'b0;
    repeat (3) begin
      tick();
      check(cke == 1'b1, "R4 held during ODT activity", cke, 1);
    end
    odt_busy = 1'b0;
    repeat (3) tick();
    check(cke == 1'b1, "R4 still settling", cke, 1);
    tick();
    check(cke == 1'b0, "R4 deferred entry served", cke, 0);
    repeat (4) tick();
    wake_settle(15);

    // R3: wake right after entry waits for the 3-edge hold
    repeat (12) tick();
    drive_entry(2'd0);
    wake = 1'b1;
    tick();
    wake = 1'b0;
    check(cke == 1'b0, "R3 hold edge 2", cke, 0);
    tick();
    check(cke == 1'b0, "R3 hold edge 3", cke, 0);
    tick();
    check(cke == 1'b1, "R3 deferred wake served", cke, 1);
    repeat (15) tick();

    // R10: entry blocked for 8 cycles after clock enable rises
    repeat (12) tick();
    drive_entry(2'd0);
    repeat (4) tick();
    wake = 1'b1;
    tick();
    wake = 1'b0;
    tick();
    tick();
    check(rd_ok == 1'b1, "R5 read flag at 2", rd_ok, 1);
    pd_pre = 1'b1;
    tick();
    pd_pre = 1'b0;
    repeat (5) tick();
    check(cke == 1'b1, "R10 entry held in ODT exit window", cke, 1);
    tick();
    check(cke == 1'b0, "R10 entry after window", cke, 0);
    repeat (4) tick();
    wake_settle(15);

    // R10: entry requested during a self refresh exit is served after it
    repeat (12) tick();
    drive_entry(2'd2);
    repeat (4) tick();
    wake = 1'b1;
    tick();
    wake = 1'b0;
    pd_act = 1'b1;
    tick();
    pd_act = 1'b0;
    guard = 0;
    while (!rd_ok && guard < 300) begin
      tick();
      guard++;
    end
    check(cke == 1'b1, "R10 no entry before exit completes", cke, 1);
    tick();
    tick();
    check(cke == 1'b0, "R10 held entry served", cke, 0);
    check(fchg == 1'b0, "R9 frequency flag low in active power-down", fchg, 0);
    repeat (4) tick();
    wake_settle(15);

    // R2: priority among simultaneous requests
    repeat (12) tick();
    pd_pre = 1'b1; pd_act = 1'b1;
    tick();
    pd_pre = 1'b0; pd_act = 1'b0;
    check(fchg == 1'b1, "R2 precharge wins over active", fchg, 1);
    repeat (4) tick();
    wake_settle(15);
    repeat (12) tick();
    sref = 1'b1; pd_pre = 1'b1;
    tick();
    sref = 1'b0; pd_pre = 1'b0;
    repeat (4) tick();
    wake_measure(rt, nt);
    check(rt == 200, "R2 self refresh wins over precharge", rt, 200);

    // R11: wake in active state ignored
    repeat (12) tick();
    wake = 1'b1;
    tick();
    wake = 1'b0;
    repeat (3) begin
      tick();
      check(cke && rd_ok && nrd_ok, "R11 stray wake no effect", cke, 1);
    end
    drive_entry(2'd1);
    repeat (6) begin
      tick();
      check(cke == 1'b0, "R11 stray wake not kept", cke, 0);
    end
    wake_settle(15);

    // R11: entry request while asleep ignored and not kept
    repeat (12) tick();
    drive_entry(2'd1);
    tick();
    sref = 1'b1;
    tick();
    sref = 1'b0;
    check(fchg == 1'b0, "R11 no move to self refresh", fchg, 0);
    repeat (2) tick();
    wake_settle(15);
    repeat (10) begin
      tick();
      check(cke == 1'b1, "R11 stray entry not kept", cke, 1);
    end

    report();
  end

endmodule